// File: doc/BRIEF.md
# Serial NOR Identification and Geometry Probe

This block sits between a host and a serial NOR flash on a four-wire SPI link (mode 0, most significant bit first). When reset is released it runs one identification frame with no host action. It selects the flash, sends the identify opcode, and clocks in the three identifier bytes. It then checks them against a configured vendor and type and turns the capacity code into the device size and the page, sector and block counts. It also raises a flag that tells later command logic to use four-byte addresses.

Once the identifier is known, the host may request the device's 64-bit unique serial number. The block then runs a second frame: the serial opcode, four filler bytes, and eight captured bytes. Each frame ends with a one-cycle `done` pulse. In that same cycle the affected result outputs become valid.

Top module: `norIdProbe`

## Requirements
- R1: After reset is released, the block runs exactly one frame on its own. In that frame chip select is driven low, opcode 9Fh is sent, then three filler bytes of value FFh. Each byte is eight clock pulses, most significant bit first. MOSI changes only while SCLK is low. MISO is sampled on the rising edge, and SCLK idles low whenever chip select is high.
- R2: The three bytes received after 9Fh are, in order, the vendor byte, the type byte and the capacity code. `jedecId` presents them as {vendor, type, capacity}, with the vendor in bits 23:16.
- R3: A device is recognised when the vendor byte is EFh, the type byte is 40h and the capacity code is between 11h and 20h inclusive. Otherwise `idError`=1 and `idValid`=0, and capacity, counts and `addr4Byte` are all zero. For a recognised device `idError`=0 and `idValid`=1.
- R4: For a recognised device, `capacityBytes` = 2 to the power of the capacity code. `pageCount` = capacity/256, `sectorCount` = capacity/4096 and `blockCount` = capacity/65536.
- R5: `addr4Byte` is 1 exactly when the device is recognised and has at least 512 blocks, that is a capacity code of 19h or more.
- R6: `done` is a single-cycle pulse after each frame. It appears only after chip select has been high for at least 2*CLK_DIV clock cycles, and the results of that frame are on the outputs in the `done` cycle.
- R7: A `uidReq` pulse while the block is idle, after the identification frame, starts one frame. The frame is opcode 4Bh, then four FFh filler bytes, then eight FFh bytes during which eight bytes are captured. The first captured byte lands in `uniqueId[63:56]` and the last in `uniqueId[7:0]`. `uidValid` rises with `done`.
- R8: Between two frames, chip select stays high for at least one SPI clock period (2*CLK_DIV clock cycles).
- R9: A `uidReq` pulse that arrives while a frame is in progress is ignored: no further frame follows, and `uidValid` stays 0.
- R10: While reset is held: `spiCsN`=1, `spiSclk`=0, `done`=0, `idValid`=0, `idError`=0 and `uidValid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| uidReq | input | 1 | Request a unique serial number read |
| spiCsN | output | 1 | Flash chip select, active low |
| spiSclk | output | 1 | SPI clock, idle low |
| spiMosi | output | 1 | Serial data to the flash |
| spiMiso | input | 1 | Serial data from the flash |
| done | output | 1 | One-cycle frame completion pulse |
| idValid | output | 1 | Recognised device identified |
| idError | output | 1 | Identifier outside the accepted set |
| uidValid | output | 1 | `uniqueId` holds a captured serial number |
| jedecId | output | 24 | {vendor, type, capacity code} |
| capacityBytes | output | CAP_CODE_MAX+1 | Device size in bytes |
| blockCount | output | CAP_CODE_MAX-15 | Number of 64 KiB blocks |
| sectorCount | output | CAP_CODE_MAX-11 | Number of 4 KiB sectors |
| pageCount | output | CAP_CODE_MAX-7 | Number of 256-byte pages |
| addr4Byte | output | 1 | Later commands need four-byte addresses |
| uniqueId | output | 64 | Captured serial number |

## Verification
The assertions assume a flash that drives MISO in step with mode 0, changing it only after the rising edge on which the block samples it. They also assume `uidReq` is a level the host holds for whole clock cycles. The bench flash model updates MISO from a bit counter that advances on each SCLK rising edge, so every bit is stable at the sampling edge. The bench drives `uidReq` and reset only on falling clock edges, as single-cycle pulses. Identifier patterns span both capacity limits, both codes just outside them, the 512-block boundary on both sides, and a wrong vendor and a wrong type.

// File: rtl/norProbePkg.sv
package norProbePkg;
  localparam logic [7:0] OP_IDENT = 8'h9F;
  localparam logic [7:0] OP_SERIAL = 8'h4B;
  localparam logic [7:0] FILL_BYTE = 8'hFF;

  localparam int PAGE_LG = 8;
  localparam int SECTOR_LG = 12;
  localparam int BLOCK_LG = 16;
  localparam int WIDE_ADDR_BLOCKS = 512;

  localparam logic [3:0] IDENT_LAST = 4'd3;
  localparam logic [3:0] SERIAL_LAST = 4'd12;
  localparam logic [3:0] SERIAL_FIRST_DATA = 4'd5;

  typedef struct packed {
    logic       selectOn;
    logic       byteGo;
    logic [7:0] txByte;
    logic [3:0] byteIdx;
    logic       isSerial;
    logic       latchId;
    logic       latchSerial;
  } probeStrobes_t;
endpackage

// File: rtl/norProbeCtrl.sv
module norProbeCtrl
  import norProbePkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          uidReq,
  input  logic          byteDone,
  output probeStrobes_t strobes,
  output logic          done
);
  localparam int GAP_END = 2 * CLK_DIV;
  localparam int GAP_W = $clog2(GAP_END + 1);

  typedef enum logic [2:0] {S_BOOT, S_SEND, S_WAIT, S_GAP, S_IDLE} ctrlState_t;

  ctrlState_t state;
  logic [3:0] idx;
  logic isSerial;
  logic [GAP_W-1:0] gapCnt;
  logic gapEnd;
  logic [3:0] lastIdx;

  assign gapEnd = (state == S_GAP) && (gapCnt == GAP_W'(GAP_END));
  assign lastIdx = isSerial ? SERIAL_LAST : IDENT_LAST;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_BOOT;
      idx <= '0;
      isSerial <= 1'b0;
      gapCnt <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_BOOT: begin
          state <= S_SEND;
          idx <= '0;
          isSerial <= 1'b0;
        end
        S_SEND: state <= S_WAIT;
        S_WAIT: begin
          if (byteDone) begin
            if (idx == lastIdx) begin
              state <= S_GAP;
              gapCnt <= '0;
            end else begin
              idx <= idx + 4'd1;
              state <= S_SEND;
            end
          end
        end
        S_GAP: begin
          if (gapEnd) begin
            state <= S_IDLE;
            done <= 1'b1;
          end else begin
            gapCnt <= gapCnt + 1'b1;
          end
        end
        S_IDLE: begin
          if (uidReq) begin
            state <= S_SEND;
            idx <= '0;
            isSerial <= 1'b1;
          end
        end
        default: state <= S_BOOT;
      endcase
    end
  end

  always_comb begin
    strobes.selectOn = (state == S_SEND) || (state == S_WAIT);
    strobes.byteGo = (state == S_SEND);
    strobes.txByte = (idx == 4'd0) ? (isSerial ? OP_SERIAL : OP_IDENT) : FILL_BYTE;
    strobes.byteIdx = idx;
    strobes.isSerial = isSerial;
    strobes.latchId = gapEnd && !isSerial;
    strobes.latchSerial = gapEnd && isSerial;
  end

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  select_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobes.selectOn) |=> !strobes.selectOn);

  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT && uidReq) |=> (isSerial == $past(isSerial)));
endmodule

// File: rtl/norProbeData.sv
module norProbeData
  import norProbePkg::*;
#(
  parameter int CLK_DIV = 2,
  parameter logic [7:0] VENDOR_CODE = 8'hEF,
  parameter logic [7:0] TYPE_CODE = 8'h40,
  parameter logic [7:0] CAP_CODE_MIN = 8'h11,
  parameter logic [7:0] CAP_CODE_MAX = 8'h20,
  localparam int CAP_W = int'(CAP_CODE_MAX) + 1,
  localparam int BLK_W = CAP_W - BLOCK_LG,
  localparam int SEC_W = CAP_W - SECTOR_LG,
  localparam int PG_W = CAP_W - PAGE_LG
) (
  input  logic             clk,
  input  logic             rstN,
  input  probeStrobes_t    strobes,
  output logic             byteDone,
  output logic             spiCsN,
  output logic             spiSclk,
  output logic             spiMosi,
  input  logic             spiMiso,
  output logic             idValid,
  output logic             idError,
  output logic             uidValid,
  output logic [23:0]      jedecId,
  output logic [CAP_W-1:0] capacityBytes,
  output logic [BLK_W-1:0] blockCount,
  output logic [SEC_W-1:0] sectorCount,
  output logic [PG_W-1:0]  pageCount,
  output logic             addr4Byte,
  output logic [63:0]      uniqueId
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic shActive;
  logic [DIV_W-1:0] divCnt;
  logic [7:0] txSh;
  logic [7:0] rxSh;
  logic [2:0] bitCnt;
  logic divEnd;

  assign divEnd = (divCnt == DIV_W'(CLK_DIV - 1));
  assign spiMosi = txSh[7];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shActive <= 1'b0;
      divCnt <= '0;
      txSh <= '0;
      rxSh <= '0;
      bitCnt <= '0;
      spiSclk <= 1'b0;
      byteDone <= 1'b0;
      spiCsN <= 1'b1;
    end else begin
      byteDone <= 1'b0;
      spiCsN <= !strobes.selectOn;
      if (strobes.byteGo) begin
        shActive <= 1'b1;
        txSh <= strobes.txByte;
        divCnt <= '0;
        bitCnt <= '0;
        spiSclk <= 1'b0;
      end else if (shActive) begin
        if (divEnd) begin
          divCnt <= '0;
          if (!spiSclk) begin
            spiSclk <= 1'b1;
            rxSh <= {rxSh[6:0], spiMiso};
          end else begin
            spiSclk <= 1'b0;
            txSh <= {txSh[6:0], 1'b0};
            bitCnt <= bitCnt + 3'd1;
            if (bitCnt == 3'd7) begin
              shActive <= 1'b0;
              byteDone <= 1'b1;
            end
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  logic [7:0] vendorQ, typeQ, capCodeQ;
  logic [63:0] serialSh;
  logic known;
  logic [CAP_W-1:0] nextCap;
  logic [BLK_W-1:0] nextBlocks;

  always_comb begin
    known = (vendorQ == VENDOR_CODE) && (typeQ == TYPE_CODE) &&
            (capCodeQ >= CAP_CODE_MIN) && (capCodeQ <= CAP_CODE_MAX);
    nextCap = known ? (CAP_W'(1) << capCodeQ) : '0;
    nextBlocks = nextCap[CAP_W-1 -: BLK_W];
  end

  assign jedecId = {vendorQ, typeQ, capCodeQ};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vendorQ <= '0;
      typeQ <= '0;
      capCodeQ <= '0;
      serialSh <= '0;
      uniqueId <= '0;
      uidValid <= 1'b0;
      idValid <= 1'b0;
      idError <= 1'b0;
      capacityBytes <= '0;
      blockCount <= '0;
      sectorCount <= '0;
      pageCount <= '0;
      addr4Byte <= 1'b0;
    end else begin
      if (byteDone) begin
        if (!strobes.isSerial) begin
          case (strobes.byteIdx)
            4'd1: vendorQ <= rxSh;
            4'd2: typeQ <= rxSh;
            4'd3: capCodeQ <= rxSh;
            default: ;
          endcase
        end else if (strobes.byteIdx >= SERIAL_FIRST_DATA) begin
          serialSh <= {serialSh[55:0], rxSh};
        end
      end
      if (strobes.latchId) begin
        idValid <= known;
        idError <= !known;
        capacityBytes <= nextCap;
        blockCount <= nextBlocks;
        sectorCount <= nextCap[CAP_W-1 -: SEC_W];
        pageCount <= nextCap[CAP_W-1 -: PG_W];
        addr4Byte <= known && (32'(nextBlocks) >= 32'(WIDE_ADDR_BLOCKS));
      end
      if (strobes.latchSerial) begin
        uniqueId <= serialSh;
        uidValid <= 1'b1;
      end
    end
  end

  // R1
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiSclk);

  // R1
  go_when_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.byteGo |-> !shActive);

  // R5
  wide_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    addr4Byte |-> (!idError && (32'(blockCount) >= 32'(WIDE_ADDR_BLOCKS))));

  // R3
  error_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    idError |-> (capacityBytes == '0 && !idValid && !addr4Byte));
endmodule

// File: rtl/norIdProbe.sv
module norIdProbe
  import norProbePkg::*;
#(
  parameter int CLK_DIV = 2,
  parameter logic [7:0] VENDOR_CODE = 8'hEF,
  parameter logic [7:0] TYPE_CODE = 8'h40,
  parameter logic [7:0] CAP_CODE_MIN = 8'h11,
  parameter logic [7:0] CAP_CODE_MAX = 8'h20,
  localparam int CAP_W = int'(CAP_CODE_MAX) + 1,
  localparam int BLK_W = CAP_W - BLOCK_LG,
  localparam int SEC_W = CAP_W - SECTOR_LG,
  localparam int PG_W = CAP_W - PAGE_LG
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             uidReq,
  output logic             spiCsN,
  output logic             spiSclk,
  output logic             spiMosi,
  input  logic             spiMiso,
  output logic             done,
  output logic             idValid,
  output logic             idError,
  output logic             uidValid,
  output logic [23:0]      jedecId,
  output logic [CAP_W-1:0] capacityBytes,
  output logic [BLK_W-1:0] blockCount,
  output logic [SEC_W-1:0] sectorCount,
  output logic [PG_W-1:0]  pageCount,
  output logic             addr4Byte,
  output logic [63:0]      uniqueId
);
  probeStrobes_t strobes;
  logic byteDone;

  norProbeCtrl #(.CLK_DIV(CLK_DIV)) ctrl (
    .clk(clk), .rstN(rstN), .uidReq(uidReq), .byteDone(byteDone),
    .strobes(strobes), .done(done)
  );

  norProbeData #(
    .CLK_DIV(CLK_DIV), .VENDOR_CODE(VENDOR_CODE), .TYPE_CODE(TYPE_CODE),
    .CAP_CODE_MIN(CAP_CODE_MIN), .CAP_CODE_MAX(CAP_CODE_MAX)
  ) data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .byteDone(byteDone),
    .spiCsN(spiCsN), .spiSclk(spiSclk), .spiMosi(spiMosi), .spiMiso(spiMiso),
    .idValid(idValid), .idError(idError), .uidValid(uidValid),
    .jedecId(jedecId), .capacityBytes(capacityBytes), .blockCount(blockCount),
    .sectorCount(sectorCount), .pageCount(pageCount), .addr4Byte(addr4Byte),
    .uniqueId(uniqueId)
  );
endmodule

// File: tb/norIdProbe_test.sv
module norIdProbe_test;
  localparam int DIV = 2;
  localparam realtime SPI_PERIOD = 2 * DIV * 5.0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic uidReq = 1'b0;
  logic spiCsN, spiSclk, spiMosi, spiMiso;
  logic done, idValid, idError, uidValid, addr4Byte;
  logic [23:0] jedecId;
  logic [32:0] capacityBytes;
  logic [16:0] blockCount;
  logic [20:0] sectorCount;
  logic [24:0] pageCount;
  logic [63:0] uniqueId;

  always #2.5 clk = ~clk;

  norIdProbe #(.CLK_DIV(DIV)) uut (
    .clk(clk), .rstN(rstN), .uidReq(uidReq),
    .spiCsN(spiCsN), .spiSclk(spiSclk), .spiMosi(spiMosi), .spiMiso(spiMiso),
    .done(done), .idValid(idValid), .idError(idError), .uidValid(uidValid),
    .jedecId(jedecId), .capacityBytes(capacityBytes), .blockCount(blockCount),
    .sectorCount(sectorCount), .pageCount(pageCount), .addr4Byte(addr4Byte),
    .uniqueId(uniqueId)
  );

  int nChecks = 0;
  int nErr = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Flash model
  logic [23:0] idWord = 24'h0;
  logic [63:0] serialWord = 64'h0;
  int mCount = 0;
  logic [7:0] mOp = 8'h0;
  logic [7:0] mSh = 8'h0;
  bit mAllFill = 1'b1;
  bit inFrame = 1'b0;
  bit haveRise = 1'b0;
  realtime lastRise = 0;
  int mFrames = 0;

  function automatic logic misoBit(input int n, input logic [7:0] op,
                                   input logic [23:0] idw, input logic [63:0] sw);
    int b;
    int k;
    b = n / 8;
    k = 7 - (n % 8);
    if (op == 8'h9F && b >= 1 && b <= 3) return idw[(3 - b) * 8 + k];
    if (op == 8'h4B && b >= 5 && b <= 12) return sw[(12 - b) * 8 + k];
    return 1'b0;
  endfunction

  assign spiMiso = misoBit(mCount, mOp, idWord, serialWord);

  always @(posedge spiSclk) begin
    if (spiCsN === 1'b0) begin
      if (mCount == 7) mOp = {mSh[6:0], spiMosi};
      if (mCount >= 8 && spiMosi !== 1'b1) mAllFill = 1'b0;
      mSh = {mSh[6:0], spiMosi};
      mCount = mCount + 1;
    end
  end

  always @(negedge spiCsN) begin
    if (rstN) begin
      // R1 mode 0: clock low at select
      chk(spiSclk === 1'b0, "R1 sclk low at select", 64'(spiSclk), 64'h0);
      // R8 gap between frames
      if (haveRise)
        chk(($realtime - lastRise) >= SPI_PERIOD, "R8 deselect gap",
            64'(int'($realtime - lastRise)), 64'(int'(SPI_PERIOD)));
      mCount = 0;
      mOp = 8'h0;
      mSh = 8'h0;
      mAllFill = 1'b1;
      inFrame = 1'b1;
    end
  end

  always @(posedge spiCsN) begin
    if (inFrame) begin
      inFrame = 1'b0;
      haveRise = 1'b1;
      lastRise = $realtime;
      mFrames++;
      if (mOp == 8'h9F) begin
        chk(mCount == 32, "R1 ident frame length", 64'(mCount), 64'd32);
        chk(mAllFill, "R1 ident filler FFh", 64'(mAllFill), 64'd1);
      end else if (mOp == 8'h4B) begin
        chk(mCount == 104, "R7 serial frame length", 64'(mCount), 64'd104);
        chk(mAllFill, "R7 serial filler FFh", 64'(mAllFill), 64'd1);
      end else begin
        chk(1'b0, "R1 R7 unknown opcode", 64'(mOp), 64'h9F);
      end
    end
  end

  // Scoreboard
  typedef struct {
    bit          isSerial;
    logic [23:0] id;
    bit          known;
    logic [63:0] cap;
    logic [63:0] blk;
    logic [63:0] sec;
    logic [63:0] pg;
    bit          wide;
    logic [63:0] serial;
  } expItem_t;

  expItem_t sb[$];

  always @(negedge clk) begin
    if (rstN && done === 1'b1) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R6 unexpected done", 64'd1, 64'd0);
      end else begin
        expItem_t e;
        e = sb.pop_front();
        chk(($realtime - lastRise) >= SPI_PERIOD, "R6 done after deselect",
            64'(int'($realtime - lastRise)), 64'(int'(SPI_PERIOD)));
        if (!e.isSerial) begin
          chk(jedecId === e.id, "R2 jedecId", 64'(jedecId), 64'(e.id));
          chk(idValid === e.known, "R3 idValid", 64'(idValid), 64'(e.known));
          chk(idError === !e.known, "R3 idError", 64'(idError), 64'(!e.known));
          chk(64'(capacityBytes) === e.cap, "R4 capacity", 64'(capacityBytes), e.cap);
          chk(64'(blockCount) === e.blk, "R4 blocks", 64'(blockCount), e.blk);
          chk(64'(sectorCount) === e.sec, "R4 sectors", 64'(sectorCount), e.sec);
          chk(64'(pageCount) === e.pg, "R4 pages", 64'(pageCount), e.pg);
          chk(addr4Byte === e.wide, "R5 addr4Byte", 64'(addr4Byte), 64'(e.wide));
        end else begin
          chk(uniqueId === e.serial, "R7 uniqueId", uniqueId, e.serial);
          chk(uidValid === 1'b1, "R7 uidValid", 64'(uidValid), 64'd1);
        end
      end
      @(posedge clk);
      @(negedge clk);
      chk(done === 1'b0, "R6 done one cycle", 64'(done), 64'd0);
    end
  end

  task automatic waitEmpty();
    while (sb.size() != 0) @(posedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic probe(input logic [23:0] id, input bit poke);
    expItem_t e;
    logic [7:0] c;
    c = id[7:0];
    e.isSerial = 1'b0;
    e.id = id;
    e.known = (id[23:16] == 8'hEF) && (id[15:8] == 8'h40) && (c >= 8'h11) && (c <= 8'h20);
    e.cap = e.known ? (64'd1 << c) : 64'd0;
    e.blk = e.cap / 65536;
    e.sec = e.cap / 4096;
    e.pg = e.cap / 256;
    e.wide = e.known && (e.cap >= 64'h200_0000);
    e.serial = '0;
    @(negedge clk);
    rstN = 1'b0;
    idWord = id;
    repeat (3) @(negedge clk);
    mFrames = 0;
    haveRise = 1'b0;
    inFrame = 1'b0;
    sb.push_back(e);
    rstN = 1'b1;
    if (poke) begin
      repeat (20) @(negedge clk);
      uidReq = 1'b1;
      @(negedge clk);
      uidReq = 1'b0;
    end
    waitEmpty();
  endtask

  task automatic askSerial(input logic [63:0] s);
    expItem_t e;
    e.isSerial = 1'b1;
    e.id = '0;
    e.known = 1'b0;
    e.cap = '0;
    e.blk = '0;
    e.sec = '0;
    e.pg = '0;
    e.wide = 1'b0;
    e.serial = s;
    serialWord = s;
    sb.push_back(e);
    @(negedge clk);
    uidReq = 1'b1;
    @(negedge clk);
    uidReq = 1'b0;
    waitEmpty();
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nErr++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(spiCsN === 1'b1, "R10 csN", 64'(spiCsN), 64'd1);
    chk(spiSclk === 1'b0, "R10 sclk", 64'(spiSclk), 64'd0);
    chk(done === 1'b0, "R10 done", 64'(done), 64'd0);
    chk(idValid === 1'b0 && idError === 1'b0, "R10 id flags",
        64'({idValid, idError}), 64'd0);
    chk(uidValid === 1'b0, "R10 uidValid", 64'(uidValid), 64'd0);

    // R9: request during the ident frame is dropped
    probe(24'hEF4016, 1'b1);
    repeat (120) @(negedge clk);
    chk(mFrames == 1, "R9 frame count", 64'(mFrames), 64'd1);
    chk(uidValid === 1'b0, "R9 uidValid", 64'(uidValid), 64'd0);

    askSerial(64'hA1B2_C3D4_E5F6_0718);
    chk(mFrames == 2, "R7 frame count", 64'(mFrames), 64'd2);

    probe(24'hEF4019, 1'b0);
    probe(24'hEF4018, 1'b0);
    probe(24'hEF4011, 1'b0);
    probe(24'hEF4020, 1'b0);
    askSerial(64'h0123_4567_89AB_CDEF);
    probe(24'hEF4010, 1'b0);
    probe(24'hEF4021, 1'b0);
    probe(24'hC84016, 1'b0);
    probe(24'hEF6016, 1'b0);
    askSerial(64'hFFFF_0000_8001_7FFE);

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule